// File: doc/BRIEF.md
# Programmable Tick Timer with Match Modes

This block is a tick timer for a processor subsystem. A prescaler turns the system clock into a count-enable pulse. For example, dividing a 100 MHz clock by 5 gives a 20 MHz tick, so one tick every 50 ns. On each tick a 32-bit count register advances by one. A control register holds a period field, an interrupt enable, a sticky pending flag and a two-bit action mode.

A match is detected when the low period-width bits of the incremented count equal the programmed period. The upper count bits play no part in the comparison. What happens on a match depends on the mode:

- **Restart:** the count reloads zero.
- **One-shot:** counting stops at the matching value.
- **Continuous:** the count keeps running.
- **Off:** the count stays frozen.

When the enable bit is set, a match raises the pending flag. The interrupt output is the pending flag gated by the enable.

Software uses a single-cycle write port and a combinational read port. A select bit chooses between the count register and the control register.

Top module: `tick_timer`

## Requirements
- R1: After reset the count register reads 0, the control register reads 0 and `irq` is low.
- R2: While counting, the count increases by exactly one every PRESCALE system clocks (one tick). Between ticks it holds its value.
- R3: A match happens on a tick when bits [27:0] of count+1 equal control bits [27:0] (the period). Count bits [31:28] are ignored.
- R4: On a match with control bit 29 (enable) set, control bit 28 (pending) becomes 1. A match with bit 29 clear leaves bit 28 unchanged. `irq` is high exactly when bits 28 and 29 are both 1.
- R5: Pending is sticky. A control write with bit 28 = 0 clears it, and a write with bit 28 = 1 leaves it unchanged. A match and a clearing write in the same cycle leave it set.
- R6: Mode 01 (control bits [31:30]) is restart: the matching tick loads the count with 0.
- R7: Mode 10 is one-shot: the matching tick loads the matched value, and counting then stops. Counting resumes after the next control write with a non-zero mode.
- R8: Mode 11 is continuous: the count increments through the match without change.
- R9: Mode 00 freezes the count and produces no match.
- R10: A write with select 0 loads any 32-bit value into the count, overriding a tick in the same cycle. The value reads back unchanged while counting is frozen.
- R11: If the period is less than or equal to the current masked count, the next match comes only after the 28-bit masked count wraps through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 = count, 1 = control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 = count, 1 = control |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Timer interrupt request |

## Verification
The hardest situation to reach from the ports is a control write that clears pending in exactly the cycle a match happens. Getting there needs the write to land on the one system clock in PRESCALE whose tick carries the count onto the period. The bench's behavioural model tracks the prescaler phase and the count. The stimulus polls the model at each falling edge and fires the clearing write only when the model predicts a match at the next rising edge. The wrap rule is reached the same way, by loading the count just below the 28-bit boundary so that the period is matched only after the masked field rolls over.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      MODE_OFF     = 2'b00,
      MODE_RESTART = 2'b01,
      MODE_ONESHOT = 2'b10,
      MODE_FREE    = 2'b11
   } tick_mode_e;

   localparam logic SEL_COUNT = 1'b0;
   localparam logic SEL_CTRL  = 1'b1;

   // Control fields sit above the period field, counted from its width.
   localparam int CTRL_EXTRA_BITS = 4;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("tick_prescaler: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + PW'(1);
            end
         end

         assign tick = (phase_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/tick_count_unit.sv
module tick_count_unit
   import tick_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  tick_mode_e        mode,
   input  logic [PERIOD_W-1:0] period,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] count,
   output logic              match
);

   generate
      if (PERIOD_W > DATA_W) begin : g_bad_width
         $error("tick_count_unit: PERIOD_W exceeds DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] count_q;
   logic [DATA_W-1:0] count_inc;
   logic              step;

   assign step      = run & tick;
   assign count_inc = count_q + DATA_W'(1);
   assign match     = step & (count_inc[PERIOD_W-1:0] == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (step) begin
         if (match && mode == MODE_RESTART) begin
            count_q <= '0;
         end else begin
            count_q <= count_inc;
         end
      end
   end

   assign count = count_q;

endmodule

// File: rtl/tick_ctrl_unit.sv
module tick_ctrl_unit
   import tick_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                match,
   output logic [PERIOD_W-1:0] period,
   output tick_mode_e          mode,
   output logic                run,
   output logic                irq,
   output logic [DATA_W-1:0]   ctrl
);

   localparam int PEND_BIT = PERIOD_W;
   localparam int IE_BIT   = PERIOD_W + 1;
   localparam int MODE_LO  = PERIOD_W + 2;

   generate
      if (PERIOD_W + CTRL_EXTRA_BITS != DATA_W) begin : g_bad_layout
         $error("tick_ctrl_unit: DATA_W must equal PERIOD_W + 4");
      end
   endgenerate

   logic [PERIOD_W-1:0] period_q;
   logic                pend_q;
   logic                ie_q;
   tick_mode_e          mode_q;
   logic                run_q;
   logic                hit;
   tick_mode_e          wmode;

   assign hit   = match & ie_q;
   assign wmode = tick_mode_e'(wdata[MODE_LO +: 2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         pend_q   <= 1'b0;
         ie_q     <= 1'b0;
         mode_q   <= MODE_OFF;
         run_q    <= 1'b0;
      end else if (wr) begin
         period_q <= wdata[PERIOD_W-1:0];
         ie_q     <= wdata[IE_BIT];
         mode_q   <= wmode;
         pend_q   <= hit | (pend_q & wdata[PEND_BIT]);
         run_q    <= (wmode != MODE_OFF);
      end else begin
         if (hit) begin
            pend_q <= 1'b1;
         end
         if (match && mode_q == MODE_ONESHOT) begin
            run_q <= 1'b0;
         end
      end
   end

   assign period = period_q;
   assign mode   = mode_q;
   assign run    = run_q;
   assign irq    = pend_q & ie_q;
   assign ctrl   = {mode_q, ie_q, pend_q, period_q};

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PRESCALE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);

   localparam int PERIOD_W = DATA_W - CTRL_EXTRA_BITS;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("tick_timer: DATA_W must be at least 8");
      end
   endgenerate

   logic                tick;
   logic                match;
   logic                run;
   tick_mode_e          mode;
   logic [PERIOD_W-1:0] period;
   logic [DATA_W-1:0]   count_q;
   logic [DATA_W-1:0]   ctrl_q;
   logic                cnt_wr;
   logic                ctl_wr;

   assign cnt_wr = wr_en & (wr_sel == SEL_COUNT);
   assign ctl_wr = wr_en & (wr_sel == SEL_CTRL);

   tick_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   tick_count_unit #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (run),
      .mode     (mode),
      .period   (period),
      .load     (cnt_wr),
      .load_val (wr_data),
      .count    (count_q),
      .match    (match)
   );

   tick_ctrl_unit #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctl_wr),
      .wdata  (wr_data),
      .match  (match),
      .period (period),
      .mode   (mode),
      .run    (run),
      .irq    (irq),
      .ctrl   (ctrl_q)
   );

   assign rd_data = (rd_sel == SEL_CTRL) ? ctrl_q : count_q;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] count,
   input logic [DATA_W-1:0] ctrl,
   input logic              irq
);

   localparam int PW = DATA_W - 4;

   logic pend;
   logic ie;
   logic [1:0] mode;
   logic cnt_wr;
   logic ctl_wr;

   assign pend   = ctrl[PW];
   assign ie     = ctrl[PW+1];
   assign mode   = ctrl[PW+3:PW+2];
   assign cnt_wr = wr_en & ~wr_sel;
   assign ctl_wr = wr_en & wr_sel;

   AST_PEND_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !$past(pend)) |-> $past(ie)); // R4

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend) && !$past(ctl_wr)) |-> pend); // R5

   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !cnt_wr) |=> (count == $past(count))); // R9

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_wr) && count != $past(count)) |->
         (count == $past(count) + DATA_W'(1) || count == '0)); // R2

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend && ie)); // R4

endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_sel (wr_sel),
   .count  (count_q),
   .ctrl   (ctrl_q),
   .irq    (irq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int QTR = CLK_PERIOD / 4;
   localparam int PRE = 5;
   localparam logic [31:0] MASK = 32'h0FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        irq;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tick_timer #(.DATA_W(32), .PRESCALE(PRE)) u_tick_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   // Behavioural reference model
   int          m_pre = 0;
   logic [31:0] m_cnt = '0;
   logic [31:0] m_ctrl = '0;
   bit          m_run = 0;

   function automatic bit will_match();
      logic [31:0] nx;
      nx = m_cnt + 32'd1;
      return m_run && (m_pre == PRE - 1) && ((nx & MASK) == (m_ctrl & MASK));
   endfunction

   always @(posedge clk) begin
      bit t, mt, hit;
      logic [31:0] nx;
      if (!rst_n) begin
         m_pre = 0; m_cnt = '0; m_ctrl = '0; m_run = 0;
      end else begin
         mt = will_match();
         t = (m_pre == PRE - 1);
         hit = mt && m_ctrl[29];
         nx = m_cnt + 32'd1;
         if (wr_en && !wr_sel) m_cnt = wr_data;
         else if (m_run && t) m_cnt = (mt && m_ctrl[31:30] == 2'b01) ? 32'd0 : nx;
         if (wr_en && wr_sel) begin
            m_ctrl = wr_data;
            m_ctrl[28] = hit || (m_ctrl[28] && wr_data[28]);
            m_run = (wr_data[31:30] != 2'b00);
         end else begin
            if (hit) m_ctrl[28] = 1'b1;
            if (mt && m_ctrl[31:30] == 2'b10) m_run = 0;
         end
         m_pre = t ? 0 : m_pre + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Per-clock comparison against the model
   always @(posedge clk) begin
      logic [31:0] e;
      #(QTR);
      if (rst_n && !done) begin
         e = rd_sel ? m_ctrl : m_cnt;
         chk(rd_data === e, rd_sel ? "R5 trace ctrl" : "R2 trace count", rd_data, e);
         chk(irq === (m_ctrl[28] & m_ctrl[29]), "R4 trace irq",
             {31'd0, irq}, {31'd0, m_ctrl[28] & m_ctrl[29]});
      end
   end

   task automatic wr(input logic s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic s, output logic [31:0] v);
      @(negedge clk);
      rd_sel = s;
      #1;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] mk(input logic [1:0] md, input bit ie,
                                      input bit pd, input logic [27:0] per);
      return {md, ie, pd, per};
   endfunction

   initial begin
      logic [31:0] v, v2;
      bit hit, ok;
      idle(3);
      rst_n = 1'b1;

      rd(1'b0, v); chk(v == 0, "R1 reset count", v, 0);
      rd(1'b1, v); chk(v == 0, "R1 reset ctrl", v, 0);
      chk(irq == 0, "R1 reset irq", {31'd0, irq}, 0);

      idle(20);
      rd(1'b0, v); chk(v == 0, "R9 mode off frozen", v, 0);

      wr(1'b0, 32'h1234_5678);
      rd(1'b0, v); chk(v == 32'h1234_5678, "R10 count readback", v, 32'h1234_5678);
      wr(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, v); chk(v == 32'hFFFF_FFFF, "R10 count readback ones", v, 32'hFFFF_FFFF);

      // Prescaler rate in continuous mode
      wr(1'b0, 32'd0);
      wr(1'b1, mk(2'b11, 1'b0, 1'b0, 28'd1000));
      idle(10 * PRE);
      rd(1'b0, v);
      chk(v >= 9 && v <= 11, "R2 tick rate", v, 10);

      // Continuous with interrupt
      wr(1'b1, mk(2'b00, 1'b0, 1'b0, 28'd0));
      wr(1'b0, 32'd0);
      wr(1'b1, mk(2'b11, 1'b1, 1'b0, 28'd4));
      idle(8 * PRE);
      chk(irq == 1, "R4 irq on match", {31'd0, irq}, 1);
      rd(1'b0, v); chk(v > 4, "R8 continuous runs past period", v, 5);
      rd(1'b1, v); chk(v[28] == 1, "R4 pending set", v, 32'h1000_0000);
      wr(1'b1, mk(2'b11, 1'b1, 1'b1, 28'd4));
      rd(1'b1, v); chk(v[28] == 1, "R5 write one keeps pending", v[28], 1);
      wr(1'b1, mk(2'b11, 1'b1, 1'b0, 28'd4));
      rd(1'b1, v); chk(v[28] == 0, "R5 write zero clears", v[28], 0);
      chk(irq == 0, "R5 irq low after clear", {31'd0, irq}, 0);

      // Restart mode
      wr(1'b1, mk(2'b00, 1'b0, 1'b0, 28'd0));
      wr(1'b0, 32'd0);
      wr(1'b1, mk(2'b01, 1'b1, 1'b0, 28'd3));
      ok = 1;
      for (int i = 0; i < 60; i++) begin
         rd(1'b0, v);
         if (v > 3) ok = 0;
      end
      chk(ok, "R6 restart bounds count", v, 3);
      chk(irq == 1, "R6 restart raises irq", {31'd0, irq}, 1);

      // One-shot
      wr(1'b1, mk(2'b00, 1'b0, 1'b0, 28'd0));
      wr(1'b0, 32'd0);
      wr(1'b1, mk(2'b10, 1'b0, 1'b0, 28'd2));
      idle(8 * PRE);
      rd(1'b0, v); chk(v == 2, "R7 one-shot stops at period", v, 2);
      idle(4 * PRE);
      rd(1'b0, v); chk(v == 2, "R7 one-shot holds", v, 2);
      chk(irq == 0, "R4 no irq when disabled", {31'd0, irq}, 0);
      wr(1'b1, mk(2'b10, 1'b0, 1'b0, 28'd2));
      idle(4 * PRE);
      rd(1'b0, v); chk(v > 2, "R7 one-shot resumes on write", v, 3);

      // Upper bits ignored
      wr(1'b1, mk(2'b00, 1'b0, 1'b0, 28'd0));
      wr(1'b0, 32'hA000_0000);
      wr(1'b1, mk(2'b11, 1'b1, 1'b0, 28'd3));
      idle(5 * PRE);
      chk(irq == 1, "R3 upper count bits ignored", {31'd0, irq}, 1);
      rd(1'b0, v); chk(v[31:28] == 4'hA, "R3 upper bits kept", v, 32'hA000_0000);

      // Period equal to current count: needs full wrap
      wr(1'b1, mk(2'b00, 1'b0, 1'b0, 28'd0));
      wr(1'b0, 32'd5);
      wr(1'b1, mk(2'b11, 1'b1, 1'b0, 28'd5));
      idle(10 * PRE);
      chk(irq == 0, "R11 no match without wrap", {31'd0, irq}, 0);

      // Wrap through zero in restart mode, enable off
      wr(1'b1, mk(2'b00, 1'b0, 1'b0, 28'd0));
      wr(1'b0, 32'h0FFF_FFF8);
      wr(1'b1, mk(2'b01, 1'b0, 1'b0, 28'd2));
      idle(14 * PRE);
      rd(1'b0, v); chk(v < 8, "R11 match after wrap restarts", v, 0);
      rd(1'b1, v2); chk(v2[28] == 0, "R4 no pending with enable off", v2[28], 0);

      // Count write overrides tick
      wr(1'b1, mk(2'b11, 1'b0, 1'b0, 28'd500));
      hit = 0;
      for (int i = 0; i < 50 && !hit; i++) begin
         @(negedge clk);
         if (m_pre == PRE - 1) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'd77; hit = 1;
         end
      end
      @(negedge clk); wr_en = 1'b0;
      #1; rd_sel = 1'b0; #1;
      chk(rd_data == 32'd77, "R10 write beats tick", rd_data, 32'd77);

      // Match and clear in the same cycle
      wr(1'b1, mk(2'b00, 1'b0, 1'b0, 28'd0));
      wr(1'b0, 32'd0);
      wr(1'b1, mk(2'b11, 1'b1, 1'b0, 28'd6));
      hit = 0;
      for (int i = 0; i < 200 && !hit; i++) begin
         @(negedge clk);
         if (will_match()) begin
            wr_en = 1'b1; wr_sel = 1'b1; wr_data = mk(2'b11, 1'b1, 1'b0, 28'd6);
            hit = 1;
         end
      end
      @(negedge clk); wr_en = 1'b0;
      chk(hit, "R5 reached match cycle", {31'd0, hit}, 1);
      rd(1'b1, v); chk(v[28] == 1, "R5 match beats clear", v[28], 1);

      idle(5);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule